// File: doc/BRIEF.md
# Per-Field Vertical Blanking Generator

This block produces the vertical blanking strobe for an interlaced, two-field video display path. It runs a pixel counter and a line counter over a frame whose size software sets. It compares the live counter position with a pair of coordinates for the field named by the `field_sel` input. The blanking output switches on one clock after the counters reach the field's "on" point, where pixel and line must both match. It switches off one clock after they reach the field's "off" point.

A second output tracks the vertical flag carried in embedded timing codes. It uses its own pair of line numbers per field and compares lines only. The two outputs are therefore programmed and timed independently of each other.

Software reaches eight 32-bit registers over a plain write/read bus. Writes take effect on the clock edge. Reads are combinational.

| Address | Register contents |
|---|---|
| 0 | Field-0 blanking on point |
| 1 | Field-0 blanking off point |
| 2 | Field-1 blanking on point |
| 3 | Field-1 blanking off point |
| 4 | Field-0 flag line span |
| 5 | Field-1 flag line span |
| 6 | Last pixel index of a line, in bits 11:0 |
| 7 | Last line index of a frame, in bits 11:0 |

Top module: `vblank_gen`

## Requirements
- R1: When `pix_cnt` equals the selected field's on-point pixel and `line_cnt` equals its on-point line in the same cycle, and the off point does not match in that cycle, `vblank` is 1 from the next cycle.
- R2: When `pix_cnt` and `line_cnt` both equal the selected field's off point, `vblank` is 0 from the next cycle.
- R3: `field_sel`=0 selects the coordinates in registers 0, 1 and 4. `field_sel`=1 selects those in registers 2, 3 and 5. The other field's registers have no effect on the outputs.
- R4: In each point register, the line number sits in bits 27:16 and the pixel number in bits 11:0. Each is 12 bits wide. A register reads back the value last written to its coordinate bits.
- R5: Bits 31:28 and 15:12 of every register always read as 0. Setting them on a write changes neither the readback nor the outputs.
- R6: If the on point and the off point both match in the same cycle, `vblank` is 0 in the next cycle.
- R7: `vblank` holds its value in every cycle where neither point fully matches. A match on the pixel alone or on the line alone has no effect.
- R8: `pix_cnt` advances by 1 each cycle. When it is greater than or equal to register 6, it returns to 0 on the next cycle and `line_cnt` advances. When `line_cnt` is also greater than or equal to register 7, `line_cnt` returns to 0 instead.
- R9: The flag span register holds a first line in bits 27:16 and a last line in bits 11:0. `vbit` is 1 in the cycle after `line_cnt` equals the selected first line. It is 0 in the cycle after `line_cnt` equals the selected last line, and the last line wins when both are equal. Otherwise `vbit` holds its value. Pixel position and the blanking points do not affect it.
- R10: After reset, both counters are 0, `vblank` and `vbit` are 0, and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| field_sel | input | 1 | Field whose coordinate set is compared |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for both reads and writes |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| pix_cnt | output | 12 | Current pixel position within the line |
| line_cnt | output | 12 | Current line position within the frame |
| vblank | output | 1 | Vertical blanking strobe |
| vbit | output | 1 | Vertical flag for embedded timing codes |

## Verification
The properties assume that `field_sel` and the register contents change only through clocked inputs. Every edge of an output is then traced to a match seen one cycle earlier. The properties also assume that a newly written frame size is honoured on the very next edge, even if the counters currently sit beyond it. The stimulus drives all inputs just after a rising edge. It always sets the frame size before running a vector. It deliberately includes coordinates beyond the frame, identical on and off points, and a window that spans the frame wrap, so that every path the properties describe is reached.

// File: rtl/vbk_pkg.sv
package vbk_pkg;

    localparam int unsigned CRD_W    = 12;
    localparam int unsigned REG_W    = 32;
    localparam int unsigned LINE_LSB = 16;
    localparam int unsigned NFLD     = 2;
    localparam int unsigned ADDR_W   = 3;

    typedef logic [CRD_W-1:0] crd_t;

    typedef struct packed {
        crd_t line;
        crd_t pix;
    } point_t;

    typedef struct packed {
        point_t start;
        point_t stop;
    } window_t;

    typedef struct packed {
        crd_t first;
        crd_t last;
    } vspan_t;

    typedef struct packed {
        window_t [NFLD-1:0] win;
        vspan_t  [NFLD-1:0] vsp;
        crd_t               pix_last;
        crd_t               line_last;
    } regs_t;

    typedef struct packed {
        crd_t pix;
        crd_t line;
    } cnt_t;

    typedef struct packed {
        logic blank;
        logic vflag;
    } outs_t;

    typedef enum logic [ADDR_W-1:0] {
        A_F0_ON   = 3'd0,
        A_F0_OFF  = 3'd1,
        A_F1_ON   = 3'd2,
        A_F1_OFF  = 3'd3,
        A_F0_VSP  = 3'd4,
        A_F1_VSP  = 3'd5,
        A_PIXLAST = 3'd6,
        A_LNLAST  = 3'd7
    } addr_e;

    function automatic logic [REG_W-1:0] pack_pair(crd_t hi, crd_t lo);
        logic [REG_W-1:0] w;
        w = '0;
        w[LINE_LSB +: CRD_W] = hi;
        w[0 +: CRD_W]        = lo;
        return w;
    endfunction

endpackage

// File: rtl/vbk_regs.sv
module vbk_regs
    import vbk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output regs_t             regs
);

    regs_t regs_d, regs_q;
    crd_t  w_hi, w_lo;
    logic  unused_rsv;

    assign w_hi = bus_wdata[LINE_LSB +: CRD_W];
    assign w_lo = bus_wdata[0 +: CRD_W];
    assign unused_rsv = ^{bus_wdata[REG_W-1:LINE_LSB+CRD_W],
                          bus_wdata[LINE_LSB-1:CRD_W]};

    always_comb begin
        regs_d = regs_q;
        if (bus_wr) begin
            unique case (addr_e'(bus_addr))
                A_F0_ON:   regs_d.win[0].start = '{line: w_hi, pix: w_lo};
                A_F0_OFF:  regs_d.win[0].stop  = '{line: w_hi, pix: w_lo};
                A_F1_ON:   regs_d.win[1].start = '{line: w_hi, pix: w_lo};
                A_F1_OFF:  regs_d.win[1].stop  = '{line: w_hi, pix: w_lo};
                A_F0_VSP:  regs_d.vsp[0]       = '{first: w_hi, last: w_lo};
                A_F1_VSP:  regs_d.vsp[1]       = '{first: w_hi, last: w_lo};
                A_PIXLAST: regs_d.pix_last     = w_lo;
                A_LNLAST:  regs_d.line_last    = w_lo;
                default:   regs_d = regs_q;
            endcase
        end
    end

    always_comb begin
        unique case (addr_e'(bus_addr))
            A_F0_ON:   bus_rdata = pack_pair(regs_q.win[0].start.line, regs_q.win[0].start.pix);
            A_F0_OFF:  bus_rdata = pack_pair(regs_q.win[0].stop.line,  regs_q.win[0].stop.pix);
            A_F1_ON:   bus_rdata = pack_pair(regs_q.win[1].start.line, regs_q.win[1].start.pix);
            A_F1_OFF:  bus_rdata = pack_pair(regs_q.win[1].stop.line,  regs_q.win[1].stop.pix);
            A_F0_VSP:  bus_rdata = pack_pair(regs_q.vsp[0].first, regs_q.vsp[0].last);
            A_F1_VSP:  bus_rdata = pack_pair(regs_q.vsp[1].first, regs_q.vsp[1].last);
            A_PIXLAST: bus_rdata = pack_pair('0, regs_q.pix_last);
            A_LNLAST:  bus_rdata = pack_pair('0, regs_q.line_last);
            default:   bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;

endmodule

// File: rtl/vbk_count.sv
module vbk_count
    import vbk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  crd_t pix_last,
    input  crd_t line_last,
    output crd_t pix,
    output crd_t line
);

    cnt_t cnt_d, cnt_q;
    logic eol, eof;

    assign eol = (cnt_q.pix >= pix_last);
    assign eof = (cnt_q.line >= line_last);

    always_comb begin
        cnt_d = cnt_q;
        if (eol) begin
            cnt_d.pix  = '0;
            cnt_d.line = eof ? '0 : CRD_W'(cnt_q.line + 1'b1);
        end else begin
            cnt_d.pix  = CRD_W'(cnt_q.pix + 1'b1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign pix  = cnt_q.pix;
    assign line = cnt_q.line;

endmodule

// File: rtl/vbk_fieldcmp.sv
module vbk_fieldcmp
    import vbk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               field_sel,
    input  window_t [NFLD-1:0] win,
    input  vspan_t  [NFLD-1:0] vsp,
    input  crd_t               pix,
    input  crd_t               line,
    output logic               start_hit,
    output logic               stop_hit,
    output logic               vline_on,
    output logic               vline_off,
    output logic               vblank,
    output logic               vbit
);

    logic [NFLD-1:0] on_f, off_f, von_f, voff_f;
    outs_t           out_d, out_q;

    for (genvar f = 0; f < NFLD; f++) begin : g_fld
        assign on_f[f]   = (pix == win[f].start.pix) && (line == win[f].start.line);
        assign off_f[f]  = (pix == win[f].stop.pix)  && (line == win[f].stop.line);
        assign von_f[f]  = (line == vsp[f].first);
        assign voff_f[f] = (line == vsp[f].last);
    end

    assign start_hit = on_f[field_sel];
    assign stop_hit  = off_f[field_sel];
    assign vline_on  = von_f[field_sel];
    assign vline_off = voff_f[field_sel];

    always_comb begin
        out_d = out_q;
        if (stop_hit)       out_d.blank = 1'b0;
        else if (start_hit) out_d.blank = 1'b1;
        if (vline_off)      out_d.vflag = 1'b0;
        else if (vline_on)  out_d.vflag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign vblank = out_q.blank;
    assign vbit   = out_q.vflag;

endmodule

// File: rtl/vblank_gen.sv
module vblank_gen
    import vbk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [CRD_W-1:0]  pix_cnt,
    output logic [CRD_W-1:0]  line_cnt,
    output logic              vblank,
    output logic              vbit
);

    regs_t regs;
    crd_t  pix_last, line_last;
    logic  start_hit, stop_hit, vline_on, vline_off;

    vbk_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .regs      (regs)
    );

    assign pix_last  = regs.pix_last;
    assign line_last = regs.line_last;

    vbk_count u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_last  (pix_last),
        .line_last (line_last),
        .pix       (pix_cnt),
        .line      (line_cnt)
    );

    vbk_fieldcmp u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .field_sel (field_sel),
        .win       (regs.win),
        .vsp       (regs.vsp),
        .pix       (pix_cnt),
        .line      (line_cnt),
        .start_hit (start_hit),
        .stop_hit  (stop_hit),
        .vline_on  (vline_on),
        .vline_off (vline_off),
        .vblank    (vblank),
        .vbit      (vbit)
    );

endmodule

// File: rtl/vbk_chk.sv
module vbk_chk
    import vbk_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [CRD_W-1:0] pix_cnt,
    input logic [CRD_W-1:0] line_cnt,
    input logic [CRD_W-1:0] pix_last,
    input logic [CRD_W-1:0] line_last,
    input logic [REG_W-1:0] bus_rdata,
    input logic             start_hit,
    input logic             stop_hit,
    input logic             vline_on,
    input logic             vline_off,
    input logic             vblank,
    input logic             vbit
);

    p_rise_from_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vblank) |-> $past(start_hit));

    p_fall_from_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vblank) |-> $past(stop_hit));

    p_stop_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_hit |=> !vblank);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_hit && !stop_hit) |=> $stable(vblank));

    p_pix_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_cnt >= pix_last) |=> (pix_cnt == '0));

    p_line_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_cnt >= pix_last && line_cnt < line_last)
        |=> (line_cnt == CRD_W'($past(line_cnt) + 1'b1)));

    p_vbit_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vline_on && !vline_off) |=> vbit);

    p_vbit_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vline_off |=> !vbit);

    p_rsv_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[31:28] == 4'd0) && (bus_rdata[15:12] == 4'd0));

endmodule

bind vblank_gen vbk_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_cnt   (pix_cnt),
    .line_cnt  (line_cnt),
    .pix_last  (pix_last),
    .line_last (line_last),
    .bus_rdata (bus_rdata),
    .start_hit (start_hit),
    .stop_hit  (stop_hit),
    .vline_on  (vline_on),
    .vline_off (vline_off),
    .vblank    (vblank),
    .vbit      (vbit)
);

// File: tb/sim_vblank_gen.sv
`timescale 1ns/1ps
module sim_vblank_gen;

    localparam int PL = 15;   // last pixel index
    localparam int LL = 9;    // last line index
    localparam int NV = 5;
    localparam int FRAME = (PL + 1) * (LL + 1);

    // {sel, on_pix, on_line, off_pix, off_line, vfirst, vlast}
    localparam logic [72:0] VEC [NV] = '{
        {1'b0, 12'd3,  12'd2, 12'd10, 12'd6, 12'd1, 12'd4},
        {1'b1, 12'd12, 12'd7, 12'd1,  12'd1, 12'd8, 12'd2},
        {1'b0, 12'd0,  12'd0, 12'd15, 12'd9, 12'd0, 12'd9},
        {1'b1, 12'd5,  12'd5, 12'd5,  12'd5, 12'd3, 12'd3},
        {1'b0, 12'd20, 12'd3, 12'd2,  12'd2, 12'd6, 12'd7}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        field_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [11:0] pix_cnt, line_cnt;
    logic        vblank, vbit;

    int n_chk = 0;
    int n_bad = 0;
    bit chk_en = 1'b0;
    bit done = 1'b0;

    logic [31:0] sh [8];
    logic        m_blank, m_vbit, have_prev;
    logic [11:0] p_pix, p_line;

    always #5 clk = ~clk;

    vblank_gen u0 (
        .clk(clk), .rst_n(rst_n), .field_sel(field_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pix_cnt(pix_cnt), .line_cnt(line_cnt),
        .vblank(vblank), .vbit(vbit)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        sh[a] = d & ((a >= 3'd6) ? 32'h0000_0FFF : 32'h0FFF_0FFF);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
        bus_addr = a;
        @(negedge clk);
        check(bus_rdata === exp, req, bus_rdata, exp);
        @(posedge clk); #1;
    endtask

    // Reference model, sampled on the falling edge from ports only.
    always @(negedge clk) begin
        if (!rst_n) begin
            m_blank = 1'b0; m_vbit = 1'b0; have_prev = 1'b0;
        end else begin
            logic [31:0] on_w, off_w, vs_w;
            logic hit_on, hit_off;
            if (chk_en) begin
                check(vblank === m_blank, "R1/R2 R6 R7 vblank", {31'd0, vblank}, {31'd0, m_blank});
                check(vbit === m_vbit, "R9 vbit", {31'd0, vbit}, {31'd0, m_vbit});
                if (have_prev) begin
                    check(pix_cnt === p_pix, "R8 pix", {20'd0, pix_cnt}, {20'd0, p_pix});
                    check(line_cnt === p_line, "R8 line", {20'd0, line_cnt}, {20'd0, p_line});
                end
            end
            // R3: field_sel picks registers 0/1/4 or 2/3/5
            on_w  = field_sel ? sh[2] : sh[0];
            off_w = field_sel ? sh[3] : sh[1];
            vs_w  = field_sel ? sh[5] : sh[4];
            hit_on  = (pix_cnt == on_w[11:0])  && (line_cnt == on_w[27:16]);
            hit_off = (pix_cnt == off_w[11:0]) && (line_cnt == off_w[27:16]);
            if (hit_off)     m_blank = 1'b0;
            else if (hit_on) m_blank = 1'b1;
            if (line_cnt == vs_w[11:0])       m_vbit = 1'b0;
            else if (line_cnt == vs_w[27:16]) m_vbit = 1'b1;
            if (pix_cnt >= sh[6][11:0]) begin
                p_pix  = '0;
                p_line = (line_cnt >= sh[7][11:0]) ? 12'd0 : line_cnt + 12'd1;
            end else begin
                p_pix  = pix_cnt + 12'd1;
                p_line = line_cnt;
            end
            have_prev = 1'b1;
        end
    end

    function automatic logic [31:0] pt(input logic [11:0] ln, input logic [11:0] px);
        return {4'hF, ln, 4'hF, px};   // reserved bits set on purpose (R5)
    endfunction

    initial begin
        for (int i = 0; i < 8; i++) sh[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        check(pix_cnt === 12'd0, "R10 pix", {20'd0, pix_cnt}, 32'd0);
        check(line_cnt === 12'd0, "R10 line", {20'd0, line_cnt}, 32'd0);
        check(vblank === 1'b0, "R10 vblank", {31'd0, vblank}, 32'd0);
        check(vbit === 1'b0, "R10 vbit", {31'd0, vbit}, 32'd0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        for (int a = 0; a < 8; a++) rd(3'(a), 32'd0, "R10 reg");
        chk_en = 1'b1;

        // R5/R4: reserved bits dropped, coordinate bits kept in place
        wr(3'd2, 32'hFABC_F123);
        rd(3'd2, 32'h0ABC_0123, "R4 R5 readback");
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, 32'h0FFF_0FFF, "R5 readback");
        wr(3'd7, 32'hFFFF_FFFF);
        rd(3'd7, 32'h0000_0FFF, "R4 line-last");

        // frame size
        wr(3'd7, 32'(LL));
        wr(3'd6, 32'(PL));

        for (int v = 0; v < NV; v++) begin
            logic [72:0] e;
            logic s;
            e = VEC[v];
            s = e[72];
            // selected field gets the vector, the other a decoy (R3)
            wr(s ? 3'd2 : 3'd0, pt(e[59:48], e[71:60]));
            wr(s ? 3'd3 : 3'd1, pt(e[35:24], e[47:36]));
            wr(s ? 3'd5 : 3'd4, pt(e[23:12], e[11:0]));
            wr(s ? 3'd0 : 3'd2, pt(12'd4, 12'd7));
            wr(s ? 3'd1 : 3'd3, pt(12'd8, 12'd9));
            wr(s ? 3'd4 : 3'd5, pt(12'd5, 12'd6));
            field_sel = s;
            repeat (2 * FRAME + 7) @(posedge clk);
            #1;
        end

        // R6: identical points, never rises; R7: line-only match ignored
        wr(3'd0, pt(12'd4, 12'd6));
        wr(3'd1, pt(12'd4, 12'd6));
        field_sel = 1'b0;
        repeat (FRAME) @(posedge clk);
        #1;
        check(vblank === 1'b0, "R6 equal points", {31'd0, vblank}, 32'd0);

        chk_en = 1'b0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R8 actual=%h expected=%h", 32'd0, 32'd1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule